// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits beside the page-load logic of a byte-wide nonvolatile array and watches every qualified byte write for the two unlock sequences of a software write-protection scheme. It keeps the protection state. Each write arrives as a one-cycle strobe with a 15-bit low address and a data byte. In the same cycle the block says whether that byte belongs to a command, which is never stored, or is data. For data it also says whether the byte may be stored. A level output tells the page-load logic whether the current write cycle may change the array.

The protecting sequence is three writes: AA at 5555, then 55 at 2AAA, then A0 at 5555. The releasing sequence is six writes: AA at 5555, 55 at 2AAA, 80 at 5555, AA at 5555, 55 at 2AAA, 20 at 5555. All values are hex and are compared on the full 15-bit address. A completed sequence does not change the protection state at once. The change is held pending and takes effect when the internal write cycle that follows ends, which the page-load logic signals with `cycle_done`. This holds even when no data bytes were loaded after the sequence.

A completed sequence also opens the rest of the same load period, so the data bytes that follow it are stored even while protection is on. The page-load logic pulses `load_end` when the byte-load window closes. Any sequence still partly matched at that point is dropped.

Top module: `wps_sequencer`

## Requirements
- R1: During and right after synchronous reset, `prot_on` is 0 and `array_wr_ok` is 1.
- R2: The strobed bytes AA@5555, 55@2AAA, A0@5555 in that order each show `is_cmd`=1 and `store_byte`=0. `prot_on` becomes 1 in the cycle after the next `cycle_done` pulse.
- R3: The six strobed bytes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 in that order each show `is_cmd`=1 and `store_byte`=0. `prot_on` becomes 0 in the cycle after the next `cycle_done` pulse.
- R4: `prot_on` changes only in the cycle after a `cycle_done` pulse. A completed sequence with no data bytes after it still takes effect.
- R5: While `prot_on`=1 and no sequence has completed in the current period, `array_wr_ok`=0 and every data byte shows `store_byte`=0. A `cycle_done` then leaves `prot_on` at 1.
- R6: After a completed sequence, `array_wr_ok`=1 until the next `cycle_done`. Data bytes in that window show `store_byte`=1, whatever the protection state.
- R7: A `load_end` pulse drops a partly matched sequence. A later continuation byte, such as 55@2AAA or A0@5555, is then data, and the protection state does not change.
- R8: A byte that does not fit the next step of a partly matched sequence shows `is_cmd`=0 and is data under the current state. The matcher restarts, so the following continuation byte is data too.
- R9: The command addresses stay ordinary locations. Any byte at 5555 or 2AAA that is not the expected next step is data, and so is every byte after a completed sequence in the same period, including AA@5555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | One-cycle pulse per qualified byte write |
| wr_addr | input | 15 | Low address of the write |
| wr_data | input | 8 | Data byte of the write |
| load_end | input | 1 | Byte-load window closed; internal write cycle begins |
| cycle_done | input | 1 | Internal write cycle finished |
| is_cmd | output | 1 | The strobed byte is a command byte (never stored) |
| store_byte | output | 1 | The strobed byte is data and may be stored |
| array_wr_ok | output | 1 | The current write cycle may change the array |
| prot_on | output | 1 | Protection state |

## Verification
A matcher that has fallen out of step shows up on `is_cmd` during the very next strobe. The same byte then moves to `store_byte` or is swallowed, so the fault is visible within one write. A wrong pending or protection value shows nothing until the `cycle_done` that follows the sequence. One cycle later it appears on `prot_on` and `array_wr_ok`, and from there on every data byte of the next period shows it. The bench therefore checks whole sequences, with aborted and diverging variants, across several write cycles, comparing every output on every clock.

// File: rtl/wps_pkg.sv
// Package: shared types and key indices for the write protection sequencer.
// Assumes the five distinct command keys are indexed as listed below.
package wps_pkg;
    localparam int NKEY  = 5;
    localparam int K_AA  = 0;   // AA at first key address
    localparam int K_55  = 1;   // 55 at second key address
    localparam int K_EN  = 2;   // protect code at first key address
    localparam int K_D80 = 3;   // release prefix code at first key address
    localparam int K_D20 = 4;   // release final code at first key address

    typedef enum logic [2:0] {
        M_IDLE, M_K1, M_K2, M_D3, M_D4, M_D5, M_OPEN
    } match_st_t;

    typedef enum logic [1:0] {
        P_NONE, P_SET, P_CLR
    } pend_t;
endpackage

// File: rtl/wps_key_cmp.sv
// Key comparator: flags a write whose address and data both equal one key.
// Purely combinational; assumes the caller qualifies the result with a strobe.
module wps_key_cmp #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] K_ADDR = '0,
    parameter logic [DATA_W-1:0] K_DATA = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit
);
    // full-width address and data equality
    always_comb hit = (addr == K_ADDR) && (data == K_DATA);
endmodule

// File: rtl/wps_matcher.sv
// Sequence matcher: steps through the protect and release unlock sequences.
// Assumes load_end, cycle_done and wr_strobe never coincide; the two period
// markers take priority and return the matcher to idle.
module wps_matcher
    import wps_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_strobe,
    input  logic [NKEY-1:0] key_hit,
    input  logic            load_end,
    input  logic            cycle_done,
    output logic            is_cmd,
    output logic            en_done,
    output logic            dis_done
);
    match_st_t st, nxt;
    logic      hit, en_ev, dis_ev;

    // expected-step decode and next state for the current byte
    always_comb begin
        nxt    = st;
        hit    = 1'b0;
        en_ev  = 1'b0;
        dis_ev = 1'b0;
        case (st)
            M_IDLE: if (key_hit[K_AA]) begin hit = 1'b1; nxt = M_K1; end
            M_K1:   if (key_hit[K_55]) begin hit = 1'b1; nxt = M_K2; end
            M_K2: begin
                if (key_hit[K_EN]) begin
                    hit = 1'b1; nxt = M_OPEN; en_ev = 1'b1;
                end else if (key_hit[K_D80]) begin
                    hit = 1'b1; nxt = M_D3;
                end
            end
            M_D3:   if (key_hit[K_AA]) begin hit = 1'b1; nxt = M_D4; end
            M_D4:   if (key_hit[K_55]) begin hit = 1'b1; nxt = M_D5; end
            M_D5: begin
                if (key_hit[K_D20]) begin
                    hit = 1'b1; nxt = M_OPEN; dis_ev = 1'b1;
                end
            end
            default: ;
        endcase
        if (!hit && st != M_OPEN) nxt = M_IDLE;
    end

    // matcher state register, cleared at every period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)                      st <= M_IDLE;
        else if (cycle_done || load_end) st <= M_IDLE;
        else if (wr_strobe)              st <= nxt;
    end

    // byte classification and completion events
    always_comb begin
        is_cmd   = wr_strobe && hit;
        en_done  = wr_strobe && en_ev  && !load_end && !cycle_done;
        dis_done = wr_strobe && dis_ev && !load_end && !cycle_done;
    end
endmodule

// File: rtl/wps_prot_reg.sv
// Protection state register: holds the pending change from a completed
// sequence and the period unlock, and applies the change at cycle end.
// Assumes at most one completed sequence per load period.
module wps_prot_reg
    import wps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_done,
    input  logic dis_done,
    input  logic cycle_done,
    output logic prot_q,
    output logic unlock_q
);
    pend_t pend;

    // pending change, unlock flag and protection state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q   <= 1'b0;
            unlock_q <= 1'b0;
            pend     <= P_NONE;
        end else if (cycle_done) begin
            case (pend)
                P_SET:   prot_q <= 1'b1;
                P_CLR:   prot_q <= 1'b0;
                default: ;
            endcase
            pend     <= P_NONE;
            unlock_q <= 1'b0;
        end else if (en_done) begin
            pend     <= P_SET;
            unlock_q <= 1'b1;
        end else if (dis_done) begin
            pend     <= P_CLR;
            unlock_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wps_sequencer.sv
// Top: software write-protection command sequencer. Classifies each strobed
// byte as command or data, grants or withholds array writes, and keeps the
// protection state. Assumes the page-load logic issues no strobe while busy.
module wps_sequencer
    import wps_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_A1  = 'h5555,
    parameter logic [ADDR_W-1:0] KEY_A2  = 'h2AAA,
    parameter logic [DATA_W-1:0] KEY_DAA = 'hAA,
    parameter logic [DATA_W-1:0] KEY_D55 = 'h55,
    parameter logic [DATA_W-1:0] KEY_DEN = 'hA0,
    parameter logic [DATA_W-1:0] KEY_D80 = 'h80,
    parameter logic [DATA_W-1:0] KEY_D20 = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_end,
    input  logic              cycle_done,
    output logic              is_cmd,
    output logic              store_byte,
    output logic              array_wr_ok,
    output logic              prot_on
);
    localparam logic [ADDR_W-1:0] KA [NKEY] = '{KEY_A1, KEY_A2, KEY_A1, KEY_A1, KEY_A1};
    localparam logic [DATA_W-1:0] KD [NKEY] = '{KEY_DAA, KEY_D55, KEY_DEN, KEY_D80, KEY_D20};

    logic [NKEY-1:0] key_hit;
    logic            en_done, dis_done, prot_q, unlock_q;

    for (genvar g = 0; g < NKEY; g++) begin : g_key
        wps_key_cmp #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .K_ADDR(KA[g]), .K_DATA(KD[g])
        ) u_cmp (
            .addr(wr_addr), .data(wr_data), .hit(key_hit[g])
        );
    end

    wps_matcher u_match (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .key_hit(key_hit),
        .load_end(load_end), .cycle_done(cycle_done), .is_cmd(is_cmd),
        .en_done(en_done), .dis_done(dis_done)
    );

    wps_prot_reg u_prot (
        .clk(clk), .rst_n(rst_n), .en_done(en_done), .dis_done(dis_done),
        .cycle_done(cycle_done), .prot_q(prot_q), .unlock_q(unlock_q)
    );

    // write grant and per-byte store decision
    always_comb begin
        prot_on     = prot_q;
        array_wr_ok = !prot_q || unlock_q;
        store_byte  = wr_strobe && !is_cmd && array_wr_ok;
    end
endmodule

// File: rtl/wps_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
module wps_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_A2  = 'h2AAA,
    parameter logic [DATA_W-1:0] KEY_D55 = 'h55
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_strobe,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              load_end,
    input logic              cycle_done,
    input logic              is_cmd,
    input logic              store_byte,
    input logic              array_wr_ok,
    input logic              prot_on
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!prot_on && array_wr_ok));

    // R4
    prot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_done |=> $stable(prot_on));

    // R5
    locked_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && prot_on && !array_wr_ok) |=> prot_on);

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (array_wr_ok && !cycle_done) |=> array_wr_ok);

    // R7
    abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |=> !(wr_strobe && wr_addr == KEY_A2 && wr_data == KEY_D55 && is_cmd));

    // R2
    cmd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd || store_byte) |-> wr_strobe);
endmodule

bind wps_sequencer wps_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A2(KEY_A2), .KEY_D55(KEY_D55)
) u_chk (.*);

// File: tb/tb_wps_sequencer.sv
module tb_wps_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_end = 1'b0;
    logic        cycle_done = 1'b0;
    logic        is_cmd, store_byte, array_wr_ok, prot_on;

    int checks = 0;
    int failures = 0;
    string req = "R1";

    // behavioural reference state
    int m_pos = 0;       // 0..5 steps matched, 9 = period opened
    bit m_unl = 0;
    int m_pend = 0;      // 0 none, 1 protect, 2 release
    bit m_prot = 0;
    int rel_a[6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
    int rel_d[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

    always #5 clk = ~clk;

    wps_sequencer dut (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_end(load_end), .cycle_done(cycle_done),
        .is_cmd(is_cmd), .store_byte(store_byte), .array_wr_ok(array_wr_ok),
        .prot_on(prot_on)
    );

    function automatic bit ref_match(int pos, int a, int d);
        if (pos > 5) return 1'b0;
        if (pos == 2 && a == 'h5555 && d == 'hA0) return 1'b1;
        return (a == rel_a[pos]) && (d == rel_d[pos]);
    endfunction

    task automatic check_bit(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic s, input int a, input int d, input logic le, input logic cd);
        bit m;
        @(negedge clk);
        wr_strobe = s; wr_addr = a[14:0]; wr_data = d[7:0];
        load_end = le; cycle_done = cd;
        #3;
        m = s && ref_match(m_pos, a, d);
        check_bit("is_cmd", is_cmd, m);
        check_bit("store_byte", store_byte, s && !m && (!m_prot || m_unl));
        check_bit("array_wr_ok", array_wr_ok, !m_prot || m_unl);
        check_bit("prot_on", prot_on, m_prot);
        @(posedge clk);
        if (!rst_n) begin
            m_pos = 0; m_unl = 0; m_pend = 0; m_prot = 0;
        end else if (cd) begin
            if (m_pend == 1) m_prot = 1;
            if (m_pend == 2) m_prot = 0;
            m_pend = 0; m_unl = 0; m_pos = 0;
        end else if (le) begin
            m_pos = 0;
        end else if (s && m_pos <= 5) begin
            if (m) begin
                if (m_pos == 2 && d == 'hA0) begin m_pos = 9; m_unl = 1; m_pend = 1; end
                else if (m_pos == 5)         begin m_pos = 9; m_unl = 1; m_pend = 2; end
                else m_pos = m_pos + 1;
            end else m_pos = 0;
        end
    endtask

    task automatic wr(input int a, input int d); cyc(1'b1, a, d, 1'b0, 1'b0); endtask
    task automatic gap(input int n); for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0, 1'b0); endtask
    task automatic lend(); cyc(1'b0, 0, 0, 1'b1, 1'b0); endtask
    task automatic cdone(); cyc(1'b0, 0, 0, 1'b0, 1'b1); endtask
    task automatic close_period(); lend(); gap(3); cdone(); gap(1); endtask
    task automatic seq_protect(); wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0); endtask
    task automatic seq_release();
        wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80);
        wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h20);
    endtask

    initial begin
        req = "R1"; gap(3);
        @(negedge clk); rst_n = 1'b1;
        gap(2);

        req = "R9"; wr('h5555, 'h12); wr('h2AAA, 'h77); close_period();

        req = "R2"; seq_protect(); wr('h0100, 'h3C); wr('h0101, 'h3D);
        lend(); gap(3);
        check_bit("prot_on before cycle end", prot_on, 1'b0);
        cdone(); gap(1);
        check_bit("prot_on after protect", prot_on, 1'b1);

        req = "R5"; wr('h0200, 'h11); wr('h0201, 'h22); close_period();
        check_bit("prot_on stays", prot_on, 1'b1);

        req = "R6"; seq_protect(); wr('h0300, 'h44);
        req = "R9"; wr('h5555, 'hAA); wr('h2AAA, 'h55);
        req = "R6"; close_period();

        req = "R7"; wr('h5555, 'hAA); wr('h2AAA, 'h55); lend(); wr('h5555, 'hA0);
        wr('h2AAA, 'h55); gap(2); cdone(); gap(1);

        req = "R8"; wr('h5555, 'hAA); wr('h2AAA, 'h33); wr('h2AAA, 'h55); close_period();

        req = "R4"; seq_protect(); close_period();
        check_bit("prot_on after bare protect", prot_on, 1'b1);

        req = "R3"; seq_release(); lend(); gap(4);
        check_bit("prot_on held until cycle end", prot_on, 1'b1);
        cdone(); gap(1);
        check_bit("prot_on after release", prot_on, 1'b0);

        req = "R3"; seq_release(); wr('h0400, 'h55); close_period();

        req = "R8"; wr('h5555, 'hAA); wr('h5555, 'h99); wr('h2AAA, 'h55); close_period();

        req = "R2"; seq_protect(); close_period();
        req = "R8"; wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80); wr('h5555, 'hAA);
        wr('h2AAA, 'h99); wr('h5555, 'h20); close_period();
        check_bit("prot_on after broken release", prot_on, 1'b1);

        req = "R7"; seq_release(); close_period();
        wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80); lend(); wr('h5555, 'hAA);
        gap(1); cdone(); gap(1);

        req = "R1"; @(negedge clk); rst_n = 1'b0; gap(2);
        @(negedge clk); rst_n = 1'b1; gap(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule